// File: doc/BRIEF.md
# Paged Program Counter

This block produces the 16-bit fetch address for a 64KB program store. The address has two halves. The low byte is an in-page counter built from two chained 4-bit stages. It advances on every instruction fetch and can be loaded with any 8-bit value to make a jump inside the current page. The high byte is a page register. It changes only when an instruction writes it.

The carry out of the in-page counter never reaches the page register. Code that runs off the end of a 256-byte page wraps back to offset 0x00 of the same page. A program that spans pages must therefore end each page with an explicit page write. The block raises a one-cycle wrap flag whenever the in-page counter rolls over without a page write in the same cycle. This flag exposes a missing page change.

Top module: `paged_pc`

## Requirements
- R1: While `rst_n` is low, and after it is released, `fetch_addr` is 0x0000 and `wrap_pulse` is 0 until the first clock edge that has an active control input.
- R2: At a clock edge where `inc_en` is 1 and `lo_ld` is 0, the low byte of `fetch_addr` (bits 7:0) becomes its previous value plus one, modulo 256.
- R3: At a clock edge where `inc_en`, `lo_ld` and `pg_ld` are all 0, `fetch_addr` keeps its value.
- R4: At a clock edge where `lo_ld` is 1, bits 7:0 of `fetch_addr` take `lo_data`, whatever the value of `inc_en`.
- R5: When the low byte rolls over from 0xFF to 0x00 and `pg_ld` is 0, bits 15:8 of `fetch_addr` stay unchanged.
- R6: At a clock edge where `pg_ld` is 1, bits 15:8 of `fetch_addr` take `pg_data`. The low byte follows R2 to R4 in the same edge.
- R7: When `pg_ld` and `lo_ld` are both 1 at one edge, `fetch_addr` becomes {`pg_data`, `lo_data`} after that edge.
- R8: `wrap_pulse` is 1 for exactly the one cycle that follows an edge where the low byte stepped from 0xFF by increment while `pg_ld` and `lo_ld` were 0. At every other time it is 0, including rollovers that happen together with a page write.
- R9: An increment from a low byte whose lower nibble is 0xF carries into the upper nibble, for example 0x0F to 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Advance the in-page counter |
| lo_ld | input | 1 | Load the in-page counter from `lo_data` |
| lo_data | input | 8 | Jump target inside the page |
| pg_ld | input | 1 | Load the page register from `pg_data` |
| pg_data | input | 8 | New page number |
| fetch_addr | output | 16 | {page, in-page offset} |
| wrap_pulse | output | 1 | One-cycle flag for a rollover with no page write |

## Verification
Two pairs of functions can fall in the same cycle. A page write can coincide with a rollover of the in-page counter. A low-byte load can coincide with an increment request. The bench provokes the first pair by advancing from offset 0xFF while it writes a new page. It expects the new page at offset 0x00 and expects no wrap flag. It provokes the second pair by loading with `inc_en` held high, which must land on the loaded value exactly. It also drives both loads together to check that the far jump lands on the combined address.

// File: rtl/paged_pc.sv
module paged_pc #(
  parameter int NIB_W = 4,
  parameter int NSTG  = 2,
  parameter int PG_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inc_en,
  input  logic                          lo_ld,
  input  logic [NIB_W*NSTG-1:0]         lo_data,
  input  logic                          pg_ld,
  input  logic [PG_W-1:0]               pg_data,
  output logic [PG_W+NIB_W*NSTG-1:0]    fetch_addr,
  output logic                          wrap_pulse
);
  localparam int LO_W = NIB_W * NSTG;

  logic [NIB_W-1:0] nib_q [NSTG];
  logic [NSTG:0]    cy;
  logic [LO_W-1:0]  lo_q;
  logic [PG_W-1:0]  pg_q;
  logic             wrap_q;

  assign cy[0] = inc_en;

  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    assign cy[i+1] = cy[i] & (&nib_q[i]);
    assign lo_q[i*NIB_W +: NIB_W] = nib_q[i];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     nib_q[i] <= '0;
      else if (lo_ld) nib_q[i] <= lo_data[i*NIB_W +: NIB_W];
      else if (cy[i]) nib_q[i] <= nib_q[i] + {{(NIB_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     pg_q <= '0;
    else if (pg_ld) pg_q <= pg_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wrap_q <= 1'b0;
    else        wrap_q <= cy[NSTG] & ~lo_ld & ~pg_ld;

  assign fetch_addr = {pg_q, lo_q};
  assign wrap_pulse = wrap_q;

  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ld |=> fetch_addr[LO_W-1:0] == $past(lo_data)); // R4
  AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !lo_ld) |=> fetch_addr[LO_W-1:0] == $past(fetch_addr[LO_W-1:0]) + 1'b1); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !lo_ld && !pg_ld) |=> $stable(fetch_addr)); // R3
  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_ld |=> $stable(fetch_addr[PG_W+LO_W-1:LO_W])); // R5
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pg_ld |=> fetch_addr[PG_W+LO_W-1:LO_W] == $past(pg_data)); // R6
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> fetch_addr[LO_W-1:0] == '0); // R8
  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse); // R8
endmodule

// File: tb/paged_pc_bench.sv
`timescale 1ns/1ps
module paged_pc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_en = 1'b0, lo_ld = 1'b0, pg_ld = 1'b0;
  logic [7:0]  lo_data = '0, pg_data = '0;
  logic [15:0] fetch_addr;
  logic        wrap_pulse;

  int checks = 0, failures = 0;
  logic [7:0] m_lo = '0, m_pg = '0;
  logic [15:0] exp_addr[$];
  logic        exp_wrap[$];
  string       exp_req[$];

  always #2.5 clk = ~clk;

  paged_pc u_paged_pc (
    .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .lo_ld(lo_ld), .lo_data(lo_data),
    .pg_ld(pg_ld), .pg_data(pg_data), .fetch_addr(fetch_addr), .wrap_pulse(wrap_pulse)
  );

  task automatic check(string req, logic [15:0] a, logic w, logic [15:0] ea, logic ew);
    checks++;
    if (a !== ea || w !== ew) begin
      failures++;
      $display("FAIL %s: addr=%h wrap=%b expected addr=%h wrap=%b", req, a, w, ea, ew);
    end
  endtask

  task automatic step(logic inc, logic ll, logic [7:0] ld, logic pl, logic [7:0] pd, string req);
    logic w;
    @(negedge clk);
    inc_en = inc; lo_ld = ll; lo_data = ld; pg_ld = pl; pg_data = pd;
    w = inc && !ll && !pl && (m_lo == 8'hFF);
    if (ll) m_lo = ld; else if (inc) m_lo = m_lo + 8'd1;
    if (pl) m_pg = pd;
    exp_addr.push_back({m_pg, m_lo});
    exp_wrap.push_back(w);
    exp_req.push_back(req);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_addr.size() > 0) begin
      logic [15:0] ea;
      logic ew;
      string rq;
      ea = exp_addr.pop_front();
      ew = exp_wrap.pop_front();
      rq = exp_req.pop_front();
      check(rq, fetch_addr, wrap_pulse, ea, ew);
    end
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: addr=%h expected run end", fetch_addr);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", fetch_addr, wrap_pulse, 16'h0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", fetch_addr, wrap_pulse, 16'h0000, 1'b0);
    for (int i = 0; i < 3; i++) step(1, 0, 8'h00, 0, 8'h00, "R2");
    for (int i = 0; i < 2; i++) step(0, 0, 8'hAA, 0, 8'h55, "R3");
    step(1, 1, 8'h0E, 0, 8'h00, "R4");
    step(0, 1, 8'h0D, 0, 8'h00, "R4");
    step(1, 0, 8'h00, 0, 8'h00, "R9");
    step(1, 0, 8'h00, 0, 8'h00, "R9");
    step(1, 0, 8'h00, 0, 8'h00, "R9");
    step(0, 1, 8'hFE, 0, 8'h00, "R4");
    step(1, 0, 8'h00, 0, 8'h00, "R2");
    step(1, 0, 8'h00, 0, 8'h00, "R5_R8");
    step(1, 0, 8'h00, 0, 8'h00, "R8");
    step(1, 0, 8'h00, 1, 8'h01, "R6");
    step(0, 0, 8'h00, 1, 8'h07, "R6");
    step(0, 1, 8'hFF, 0, 8'h00, "R4");
    step(1, 0, 8'h00, 1, 8'h02, "R6_R8");
    step(0, 1, 8'hFF, 0, 8'h00, "R4");
    step(1, 1, 8'h10, 0, 8'h00, "R8");
    step(0, 1, 8'h34, 1, 8'h12, "R7");
    step(1, 1, 8'hFF, 1, 8'hAB, "R7");
    step(1, 0, 8'h00, 0, 8'h00, "R5_R8");
    step(0, 0, 8'h00, 0, 8'h00, "R3");
    step(0, 0, 8'h00, 0, 8'h00, "R3");
    step(0, 0, 8'h00, 0, 8'h00, "R3");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule